// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block is a two-wire bus master that runs whole byte-wide serial EEPROM transactions from a single command. A write command carries a 3-bit device select, an 8-bit memory location and one data byte. The block then drives the bus through start, control byte, location byte, data byte and stop. A read command carries a device select, a memory location and a byte count. The block first sets the device's internal pointer: start, control byte with write direction, location byte. It then issues a repeated start and a control byte with read direction, and clocks in the requested bytes. It acknowledges every byte except the last one, which it refuses, and then issues a stop.

Each received byte appears on `rd_data` for one cycle with `rd_valid`. If a slave refuses any byte the master sends, the block closes the bus with a stop at once and reports `error` together with `done`. The bus clock is derived from the system clock: each bit is split into four equal quarters of `QDIV` system cycles. Both bus lines are open-drain and are modelled as "pull low" outputs. Arbitration between several masters and slave clock stretching are not handled.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `busy`, `done`, `error` and `rd_valid` are low apart from the `done`/`error` pulse, and neither bus line is pulled low.
- R2: A command offered with `cmd_valid` while `busy` is low is accepted if it is a write or a read with nonzero `cmd_len`. `busy` is high from the next cycle until `done`. `done` is a single-cycle pulse in the cycle where `busy` returns low, once per accepted command.
- R3: A read command with `cmd_len` equal to zero is ignored. `busy` stays low, no start condition appears and no `done` follows.
- R4: A write produces exactly one start condition, the bytes {1010, device[2:0], 0}, the location and the data, each sent most significant bit first, and then one stop. The addressed memory cell then holds the data.
- R5: A read produces start, control byte {1010, device[2:0], 0}, location, a repeated start, control byte {1010, device[2:0], 1}, the data bytes and a stop. That is two start conditions and one stop.
- R6: In a read of N bytes the master pulls SDA low in the ninth clock of each of the first N-1 received bytes. It leaves SDA released in the ninth clock of the last byte.
- R7: Each received byte is presented once on `rd_data` with a one-cycle `rd_valid`, in bus order, exactly `cmd_len` times per successful read, and only while `busy` is high.
- R8: If SDA is high in the ninth clock of any byte the master sends, the block issues a stop without sending further bytes, raises `error` in the `done` cycle and emits no `rd_valid`. A refused write leaves memory unchanged.
- R9: SDA changes while SCL is high only for a start or stop condition, and the two line outputs never change in the same cycle.
- R10: Every SCL high pulse of a transaction lasts exactly 2*QDIV system cycles. A transaction shows 9 pulses per byte plus one per start condition.
- R11: A transaction in which every sent byte is acknowledged ends with `error` low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Offer a command (taken when `busy` is low) |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_dev | input | 3 | Device select placed in the control byte |
| cmd_mem | input | 8 | Memory location |
| cmd_wdata | input | 8 | Byte to write (write commands) |
| cmd_len | input | LEN_W | Number of bytes to read (read commands) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| error | output | 1 | Slave refused a byte; valid with `done` |
| rd_valid | output | 1 | `rd_data` carries a received byte |
| rd_data | output | 8 | Received byte |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| sda_drive_low | output | 1 | 1 = pull SDA low, 0 = release |
| sda_line | input | 1 | Resolved level of the SDA line |

## Verification
The bench builds the block with QDIV=2 and LEN_W=3. A bit then takes only eight system cycles, and the whole count range 1 to 7 can be swept one read length after another, including a read that wraps the memory pointer past the top location. The short bus clock also allows a write to each of the eight device selects, so that one behavioural EEPROM on the bus answers one select and refuses the other seven. Refusal is injected at each position of the master-sent bytes for both command kinds. High pulses of SCL are counted against the exact length that QDIV=2 implies.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    // Low-level bus actions carried out by the byte engine
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_TX    = 2'd2,
        OP_RX    = 2'd3
    } bus_op_e;

    // Transaction sequencer steps
    typedef enum logic [3:0] {
        SQ_IDLE   = 4'd0,
        SQ_START  = 4'd1,
        SQ_CTRLW  = 4'd2,
        SQ_MADDR  = 4'd3,
        SQ_WDATA  = 4'd4,
        SQ_RSTART = 4'd5,
        SQ_CTRLR  = 4'd6,
        SQ_RDBYTE = 4'd7,
        SQ_STOP   = 4'd8
    } seq_st_e;

    // Fixed upper nibble of the control byte for serial EEPROMs
    localparam logic [3:0] CTRL_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
    parameter int QDIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Counter restarts whenever the engine is idle, so each quarter is full length
    always_comb begin
        tick = en && (cnt_q == LAST);
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eeprom_pkg::*;
#(
    parameter int QDIV = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bus_op_e    op,
    input  logic [7:0] tx_byte,
    input  logic       send_ack,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       slave_ack,
    output logic       scl_low,
    output logic       sda_low
);
    localparam logic [3:0] ACK_BIT = 4'd8;

    typedef struct packed {
        logic       busy;
        bus_op_e    op;
        logic [1:0] qph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       send_ack;
        logic       slave_ack;
        logic       done;
        logic       scl_low;
        logic       sda_low;
    } eng_t;

    eng_t d, q;
    logic tick;

    i2c_quarter_timer #(.QDIV(QDIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.busy),
        .tick  (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;

        if (!q.busy) begin
            if (go) begin
                d.busy     = 1'b1;
                d.op       = op;
                d.qph      = 2'd0;
                d.bitn     = 4'd0;
                d.sh       = (op == OP_TX) ? tx_byte : 8'h00;
                d.send_ack = send_ack;
            end
        end else if (tick) begin
            // Sample at the middle of the SCL high time
            if (q.qph == 2'd1) begin
                if (q.op == OP_RX && !q.bitn[3]) begin
                    d.sh = {q.sh[6:0], sda_in};
                end
                if (q.op == OP_TX && q.bitn == ACK_BIT) begin
                    d.slave_ack = !sda_in;
                end
            end
            if (q.qph == 2'd3) begin
                if (q.op == OP_START || q.op == OP_STOP || q.bitn == ACK_BIT) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bitn = q.bitn + 4'd1;
                    d.qph  = 2'd0;
                    if (q.op == OP_TX) begin
                        d.sh = {q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                d.qph = q.qph + 2'd1;
            end
        end

        // Line levels for the quarter being entered; held when idle
        if (d.busy) begin
            d.scl_low = !((d.qph == 2'd1) || (d.qph == 2'd2) ||
                          (d.op == OP_STOP && d.qph == 2'd3));
            case (d.op)
                OP_START: d.sda_low = d.qph[1];
                OP_STOP:  d.sda_low = !d.qph[1];
                OP_TX:    d.sda_low = d.bitn[3] ? 1'b0 : !d.sh[7];
                default:  d.sda_low = d.bitn[3] ? d.send_ack : 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign rx_byte   = q.sh;
    assign slave_ack = q.slave_ack;
    assign scl_low   = q.scl_low;
    assign sda_low   = q.sda_low;
endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq
    import i2c_eeprom_pkg::*;
#(
    parameter int QDIV  = 250,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [2:0]       cmd_dev,
    input  logic [7:0]       cmd_mem,
    input  logic [7:0]       cmd_wdata,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    input  logic             sda_line
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        seq_st_e          st;
        logic             go;
        logic             rd;
        logic [2:0]       dev;
        logic [7:0]       mem;
        logic [7:0]       wdata;
        logic [LEN_W-1:0] left;
        logic             err;
        logic             busy;
        logic             done;
        logic             error;
        logic             rvalid;
        logic [7:0]       rdata;
    } seq_t;

    seq_t d, q;

    bus_op_e    eng_op;
    logic [7:0] eng_tx;
    logic       eng_send_ack;
    logic       eng_busy;
    logic       eng_done;
    logic [7:0] eng_rx;
    logic       eng_ack;

    // Action and byte presented to the engine for the current step
    always_comb begin
        case (q.st)
            SQ_START, SQ_RSTART: eng_op = OP_START;
            SQ_STOP:             eng_op = OP_STOP;
            SQ_RDBYTE:           eng_op = OP_RX;
            default:             eng_op = OP_TX;
        endcase
        case (q.st)
            SQ_CTRLW: eng_tx = {CTRL_PREFIX, q.dev, 1'b0};
            SQ_CTRLR: eng_tx = {CTRL_PREFIX, q.dev, 1'b1};
            SQ_MADDR: eng_tx = q.mem;
            default:  eng_tx = q.wdata;
        endcase
        eng_send_ack = (q.left != LEN_ONE);
    end

    i2c_byte_engine #(.QDIV(QDIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (q.go),
        .op        (eng_op),
        .tx_byte   (eng_tx),
        .send_ack  (eng_send_ack),
        .sda_in    (sda_line),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_byte   (eng_rx),
        .slave_ack (eng_ack),
        .scl_low   (scl_drive_low),
        .sda_low   (sda_drive_low)
    );

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        d.done   = 1'b0;
        d.error  = 1'b0;
        d.rvalid = 1'b0;

        if (q.st == SQ_IDLE) begin
            if (cmd_valid && (!cmd_read || (cmd_len != '0))) begin
                d.st    = SQ_START;
                d.go    = 1'b1;
                d.busy  = 1'b1;
                d.err   = 1'b0;
                d.rd    = cmd_read;
                d.dev   = cmd_dev;
                d.mem   = cmd_mem;
                d.wdata = cmd_wdata;
                d.left  = cmd_len;
            end
        end else if (eng_done) begin
            d.go = 1'b1;
            case (q.st)
                SQ_START:  d.st = SQ_CTRLW;
                SQ_RSTART: d.st = SQ_CTRLR;
                SQ_CTRLW:  d.st = eng_ack ? SQ_MADDR : SQ_STOP;
                SQ_MADDR:  d.st = !eng_ack ? SQ_STOP : (q.rd ? SQ_RSTART : SQ_WDATA);
                SQ_WDATA:  d.st = SQ_STOP;
                SQ_CTRLR:  d.st = eng_ack ? SQ_RDBYTE : SQ_STOP;
                SQ_RDBYTE: begin
                    d.rvalid = 1'b1;
                    d.rdata  = eng_rx;
                    if (q.left == LEN_ONE) begin
                        d.st = SQ_STOP;
                    end else begin
                        d.left = q.left - LEN_ONE;
                    end
                end
                default: begin
                    d.st    = SQ_IDLE;
                    d.go    = 1'b0;
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.error = q.err;
                end
            endcase
            // A refused master byte ends the transfer early
            if ((q.st == SQ_CTRLW || q.st == SQ_MADDR || q.st == SQ_WDATA ||
                 q.st == SQ_CTRLR) && !eng_ack) begin
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign error    = q.error;
    assign rd_valid = q.rvalid;
    assign rd_data  = q.rdata;
endmodule

// File: rtl/i2c_eeprom_seq_chk.sv
module i2c_eeprom_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_read,
    input logic [LEN_W-1:0] cmd_len,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             rd_valid,
    input logic             scl_drive_low,
    input logic             sda_drive_low
);
    // R1: lines released outside a command
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

    // R2: valid command taken when idle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (!cmd_read || cmd_len != '0)) |=> busy);

    // R2: done ends a busy period
    p_done_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R3: zero-length read not taken
    p_zero_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_read && cmd_len == '0) |=> !busy);

    // R8: error only reported with done
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R7: data strobes only inside a command
    p_rdv_in_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R9: the two lines never move in the same cycle
    p_one_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_drive_low) || $fell(scl_drive_low)) |-> $stable(sda_drive_low));
endmodule

bind i2c_eeprom_seq i2c_eeprom_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_read      (cmd_read),
    .cmd_len       (cmd_len),
    .busy          (busy),
    .done          (done),
    .error         (error),
    .rd_valid      (rd_valid),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_eeprom_seq_tb.sv
module i2c_eeprom_seq_tb;
    localparam int QD = 2;
    localparam int LW = 3;
    localparam logic [2:0] SLV = 3'd5;
    localparam int WAIT_LIMIT = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_read  = 1'b0;
    logic [2:0]    cmd_dev   = '0;
    logic [7:0]    cmd_mem   = '0;
    logic [7:0]    cmd_wdata = '0;
    logic [LW-1:0] cmd_len   = '0;
    logic busy, done, error, rd_valid;
    logic [7:0] rd_data;
    logic scl_drive_low, sda_drive_low;
    logic slv_pull = 1'b0;

    wire scl_w = ~scl_drive_low;
    wire sda_w = ~(sda_drive_low | slv_pull);

    i2c_eeprom_seq #(.QDIV(QD), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_dev(cmd_dev), .cmd_mem(cmd_mem), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .busy(busy), .done(done), .error(error), .rd_valid(rd_valid), .rd_data(rd_data),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_line(sda_w)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural EEPROM on the bus ----------------
    logic [7:0] mem [256];
    logic [7:0] sh = '0, txb = '0;
    int  ptr = 0, bitc = 0, totb = 0, inj_idx = -1;
    bit  active = 0, ignore = 0, txm = 0, first = 0, addr_ph = 0;
    bit  skip_fall = 0, last_ok = 0, rd_req = 0, mack = 0;
    int  n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0;

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        n_start++;
        active = 1; ignore = 0; first = 1; addr_ph = 0; txm = 0;
        bitc = 0; skip_fall = 1; slv_pull = 0;
    end

    always @(posedge sda_w) if (scl_w === 1'b1) begin
        n_stop++;
        active = 0; totb = 0; slv_pull = 0;
    end

    always @(posedge scl_w) if (active && !ignore) begin
        if (bitc < 8 && !txm) sh = {sh[6:0], sda_w};
        if (bitc == 8 && txm) begin
            mack = !sda_w;
            if (mack) n_mack++; else n_mnack++;
        end
    end

    always @(negedge scl_w) if (active && !ignore) begin
        if (skip_fall) begin
            skip_fall = 0;
        end else if (bitc < 7) begin
            bitc++;
            if (txm) slv_pull = !txb[7 - bitc];
        end else if (bitc == 7) begin
            bitc = 8;
            if (txm) begin
                slv_pull = 0;
            end else begin
                last_ok = (totb != inj_idx);
                if (first) begin
                    last_ok = last_ok && (sh[7:1] == {4'b1010, SLV});
                    rd_req  = sh[0];
                    addr_ph = last_ok && !sh[0];
                    first   = 0;
                end else if (addr_ph) begin
                    rd_req = 0;
                    if (last_ok) ptr = sh;
                    addr_ph = 0;
                end else begin
                    rd_req = 0;
                    if (last_ok) begin
                        mem[ptr] = sh;
                        ptr = (ptr + 1) % 256;
                    end
                end
                slv_pull = last_ok;
            end
        end else begin
            bitc = 0;
            if (txm) begin
                ptr = (ptr + 1) % 256;
                if (mack) begin
                    txb = mem[ptr];
                    slv_pull = !txb[7];
                end else begin
                    txm = 0; ignore = 1; slv_pull = 0;
                end
            end else begin
                totb++;
                slv_pull = 0;
                if (!last_ok) begin
                    ignore = 1;
                end else if (rd_req) begin
                    txm = 1;
                    txb = mem[ptr];
                    slv_pull = !txb[7];
                end
            end
        end
    end

    // ---------------- port monitors ----------------
    logic [7:0] rd_buf [16];
    int rd_n = 0, done_n = 0, pulses = 0, hcnt = 1000;
    bit scl_prev = 1;

    always @(negedge clk) begin
        if (rd_valid === 1'b1) begin
            if (rd_n < 16) rd_buf[rd_n] = rd_data;
            rd_n++;
        end
        if (done === 1'b1) done_n++;
        if (scl_w === 1'b1) begin
            hcnt = scl_prev ? hcnt + 1 : 1;
        end else if (scl_prev) begin
            if (hcnt == 2 * QD) pulses++;
        end
        scl_prev = (scl_w === 1'b1);
    end

    bit got_err, accepted;

    task automatic run_cmd(input bit rd, input logic [2:0] dev, input logic [7:0] ma,
                           input logic [7:0] wd, input int len);
        int w;
        n_start = 0; n_stop = 0; n_mack = 0; n_mnack = 0;
        rd_n = 0; pulses = 0; done_n = 0;
        @(negedge clk);
        cmd_read = rd; cmd_dev = dev; cmd_mem = ma; cmd_wdata = wd;
        cmd_len = LW'(len); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        accepted = busy;
        got_err = 1'b0;
        if (!accepted) begin
            repeat (40) @(negedge clk);
            return;
        end
        w = 0;
        while (done !== 1'b1 && w < WAIT_LIMIT) begin
            @(negedge clk);
            w++;
        end
        check(done === 1'b1, "R2 command completes (watchdog)", w, WAIT_LIMIT);
        got_err = (error === 1'b1);
        repeat (3) @(negedge clk);
    endtask

    // Global watchdog
    initial begin
        #1900000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] old;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && error === 1'b0 && rd_valid === 1'b0,
              "R1 outputs low in reset", int'(busy), 0);
        check(scl_w === 1'b1 && sda_w === 1'b1, "R1 lines released", int'(scl_w & sda_w), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && scl_w === 1'b1 && sda_w === 1'b1,
              "R1 idle after reset", int'(busy), 0);

        // R3 zero-length read rejected
        run_cmd(1'b1, SLV, 8'h10, 8'h00, 0);
        check(!accepted, "R3 zero length not accepted", int'(accepted), 0);
        check(n_start == 0 && done_n == 0, "R3 no bus activity", n_start + done_n, 0);

        // R4/R2/R10/R11 single write
        run_cmd(1'b0, SLV, 8'h21, 8'hC3, 0);
        check(accepted, "R2 write accepted", int'(accepted), 1);
        check(done_n == 1, "R2 one done pulse", done_n, 1);
        check(!got_err, "R11 no error on write", int'(got_err), 0);
        check(mem[8'h21] == 8'hC3, "R4 memory written", int'(mem[8'h21]), 'hC3);
        check(n_start == 1 && n_stop == 1, "R4 one start one stop", n_start * 10 + n_stop, 11);
        check(pulses == 28, "R10 write clock pulses", pulses, 28);

        // R4/R8 device select sweep
        for (int dv = 0; dv < 8; dv++) begin
            old = mem[8'h80 + dv];
            run_cmd(1'b0, 3'(dv), 8'(8'h80 + dv), 8'(dv * 29 + 3), 0);
            if (3'(dv) == SLV) begin
                check(!got_err, "R11 selected device no error", int'(got_err), 0);
                check(mem[8'h80 + dv] == 8'(dv * 29 + 3), "R4 sweep write data",
                      int'(mem[8'h80 + dv]), dv * 29 + 3);
            end else begin
                check(got_err, "R8 unselected device error", int'(got_err), 1);
                check(mem[8'h80 + dv] == old, "R8 memory unchanged", int'(mem[8'h80 + dv]), int'(old));
                check(n_start == 1 && n_stop == 1, "R8 stop after refusal", n_stop, 1);
                check(pulses == 10, "R8 no bytes after refused control", pulses, 10);
            end
        end

        // R5/R6/R7/R10 read length sweep
        for (int len = 1; len < 8; len++) begin
            int a = 8'h30 + len * 9;
            int bad = 0;
            run_cmd(1'b1, SLV, 8'(a), 8'h00, len);
            check(!got_err, "R11 read no error", int'(got_err), 0);
            check(rd_n == len, "R7 strobe count", rd_n, len);
            for (int k = 0; k < len && k < 16; k++)
                if (rd_buf[k] != mem[(a + k) % 256]) bad++;
            check(bad == 0, "R7 read data in order", bad, 0);
            check(n_mack == len - 1 && n_mnack == 1, "R6 master ack pattern",
                  n_mack * 10 + n_mnack, (len - 1) * 10 + 1);
            check(n_start == 2 && n_stop == 1, "R5 repeated start and stop",
                  n_start * 10 + n_stop, 21);
            check(pulses == 29 + 9 * len, "R10 read clock pulses", pulses, 29 + 9 * len);
        end

        // R7 read across the top of memory
        begin
            int bad = 0;
            run_cmd(1'b1, SLV, 8'hFD, 8'h00, 5);
            for (int k = 0; k < 5; k++)
                if (rd_buf[k] != mem[(8'hFD + k) % 256]) bad++;
            check(rd_n == 5 && bad == 0, "R7 wrapped read", bad, 0);
        end

        // R8 refusal injected at each master-sent byte
        for (int ix = 1; ix < 3; ix++) begin
            old = mem[8'h55];
            inj_idx = ix;
            run_cmd(1'b0, SLV, 8'h55, 8'hAA, 0);
            check(got_err && done_n == 1, "R8 write refusal error", int'(got_err), 1);
            check(mem[8'h55] == old, "R8 refused write no change", int'(mem[8'h55]), int'(old));
            check(n_stop == 1 && n_start == 1, "R8 write abort stop", n_stop, 1);
            run_cmd(1'b1, SLV, 8'h40, 8'h00, 3);
            check(got_err, "R8 read refusal error", int'(got_err), 1);
            check(rd_n == 0, "R8 no data after refusal", rd_n, 0);
            check(n_stop == 1, "R8 read abort stop", n_stop, 1);
            inj_idx = -1;
        end

        // R9 the monitors would count extra starts/stops on illegal SDA moves
        run_cmd(1'b0, SLV, 8'h7E, 8'h5A, 0);
        check(n_start == 1 && n_stop == 1 && mem[8'h7E] == 8'h5A,
              "R9 clean data framing", n_start + n_stop, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule